// File: doc/BRIEF.md
# Banked Deep FIFO with Register Prefetch

This is a single-clock first-in first-out queue for 72-bit words, deep enough to hold 8193 entries. Bulk storage is sixteen synchronous RAM banks of 512 words each. The banks are stacked by depth, so the top four bits of a RAM pointer pick the bank. A small group of register slots holds the front of the queue, and the word shown on `pop_data` always comes from one of these slots. The consumer's pop decision therefore never passes combinationally through a RAM read or the bank merge logic.

Address, write data and read control are registered before they reach the banks. A bank read then passes through a synchronous RAM read, a registered four-bank group select and a registered final select before it lands in a slot. A read is issued only when a slot is still free once the words already in flight are counted. A pop in the same cycle frees a slot, so steady pops run at one word per cycle. While no data waits in the RAM or in the pipeline, a push goes straight into a slot. The output is first-word-fall-through: while `empty` is low, `pop_data` shows the oldest word, and `pop` consumes it.

Top module: `bfifo_top`

## Requirements
- R1: Synchronous reset drives `empty` high, `prog_empty` high, `full`, `prog_full`, `overflow` and `underflow` low, and `level` to 0.
- R2: Words leave in the order they were accepted. While `empty` is low, `pop_data` carries the oldest word, and asserting `pop` removes it at the clock edge.
- R3: A push into an empty queue makes `empty` low on the first clock edge, so the word is visible in the next cycle.
- R4: Once words held in RAM are reached, pops on every cycle are all accepted, with `empty` staying low until the last word leaves.
- R5: Capacity is 8193 words. `full` is high exactly when `level` equals 8193, and every word stored across all sixteen banks is returned intact.
- R6: A push while `full` is high is ignored: `level` and the queue contents do not change, and `overflow` is high for the single following cycle only.
- R7: A pop while `empty` is high is ignored: `level` stays unchanged, and `underflow` is high for the single following cycle only.
- R8: `level` equals accepted pushes minus accepted pops, counting words held in prefetch slots and in flight.
- R9: `prog_full` is high exactly when `level` is 8001 or more.
- R10: `prog_empty` is high exactly when `level` is 10 or less.
- R11: A push and a pop in the same cycle on a non-empty queue both take effect, leaving `level` unchanged.
- R12: While `empty` is low and no pop is applied, `pop_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| push_data | input | 72 | Word to enqueue |
| full | output | 1 | Queue holds 8193 words |
| pop | input | 1 | Read request, consumes the word on `pop_data` |
| pop_data | output | 72 | Oldest word, valid while `empty` is low |
| empty | output | 1 | No word ready at the output |
| prog_full | output | 1 | Occupancy at or above 8001 |
| prog_empty | output | 1 | Occupancy at or below 10 |
| level | output | 14 | Current occupancy |
| overflow | output | 1 | One-cycle pulse after a rejected push |
| underflow | output | 1 | One-cycle pulse after a rejected pop |

## Verification
The hardest condition to reach from the ports is the handover from words that bypassed into the slots to words that must come back through the five-cycle bank pipeline. Pops must then run at full rate while the slots drain down to a single word. The stimulus table reaches this by pushing past the slot count and then popping on every cycle, checking `empty` after each edge. A directed fill to 8193 words sends data through every bank and across both threshold boundaries. It is followed by a rejected push and then a full-rate drain that compares every word.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  // Registered steps between a read issue decision and prefetch slot write:
  // bank address register, synchronous bank read, group select, final select.
  localparam int unsigned BF_READ_STAGES = 4;

  // Banks merged by the first select level.
  localparam int unsigned BF_GROUP_SIZE = 4;

endpackage

// File: rtl/bfifo_bank_ram.sv
module bfifo_bank_ram #(
  parameter int unsigned W     = 72,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/bfifo_read_merge.sv
module bfifo_read_merge #(
  parameter int unsigned W       = 72,
  parameter int unsigned N_BANKS = 16,
  parameter int unsigned GROUP   = 4,
  localparam int unsigned NG     = N_BANKS / GROUP,
  localparam int unsigned BSW    = $clog2(N_BANKS),
  localparam int unsigned LW     = $clog2(GROUP),
  localparam int unsigned HW     = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_v,
  input  logic [BSW-1:0]                in_bank,
  input  logic [N_BANKS-1:0][W-1:0]     bank_q,
  output logic                          out_v,
  output logic [W-1:0]                  out_data
);

  logic               v_a, v_b;
  logic [BSW-1:0]     bank_a;
  logic [HW-1:0]      hi_b;
  logic [NG-1:0][W-1:0] grp_q;

  // Valid tags follow the data through the bank read, group and final stages.
  always_ff @(posedge clk) begin
    if (rst) begin
      v_a   <= 1'b0;
      v_b   <= 1'b0;
      out_v <= 1'b0;
    end else begin
      v_a   <= in_v;
      v_b   <= v_a;
      out_v <= v_b;
    end
  end

  always_ff @(posedge clk) begin
    bank_a <= in_bank;
    hi_b   <= HW'(bank_a >> LW);
  end

  // First level: one register per group picks one of its banks.
  for (genvar g = 0; g < NG; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (v_a) grp_q[g] <= bank_q[BSW'(g * GROUP) + BSW'(bank_a[LW-1:0])];
    end
  end

  // Second level: pick the group, registered for routing slack.
  always_ff @(posedge clk) begin
    if (v_b) out_data <= grp_q[hi_b];
  end

endmodule

// File: rtl/bfifo_prefetch.sv
module bfifo_prefetch #(
  parameter int unsigned W     = 72,
  parameter int unsigned SLOTS = 5,
  localparam int unsigned IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt
);

  logic [W-1:0]  slot [SLOTS];
  logic [IW-1:0] wr_idx, rd_idx;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] i);
    return (i == IW'(SLOTS - 1)) ? '0 : i + IW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en) wr_idx <= bump(wr_idx);
      if (rd_en) rd_idx <= bump(rd_idx);
      cnt <= cnt + CW'(wr_en) - CW'(rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  assign head = slot[rd_idx];

endmodule

// File: rtl/bfifo_top.sv
module bfifo_top
  import bfifo_pkg::*;
#(
  parameter int unsigned DATA_W        = 72,
  parameter int unsigned BANK_DEPTH    = 512,
  parameter int unsigned N_BANKS       = 16,
  parameter int unsigned PROG_FULL_TH  = 8001,
  parameter int unsigned PROG_EMPTY_TH = 10
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         push,
  input  logic [DATA_W-1:0]                            push_data,
  output logic                                         full,
  input  logic                                         pop,
  output logic [DATA_W-1:0]                            pop_data,
  output logic                                         empty,
  output logic                                         prog_full,
  output logic                                         prog_empty,
  output logic [$clog2(BANK_DEPTH*N_BANKS+2)-1:0]      level,
  output logic                                         overflow,
  output logic                                         underflow
);

  localparam int unsigned RAM_DEPTH = BANK_DEPTH * N_BANKS;
  localparam int unsigned AW        = $clog2(RAM_DEPTH);
  localparam int unsigned BAW       = $clog2(BANK_DEPTH);
  localparam int unsigned BSW       = $clog2(N_BANKS);
  localparam int unsigned CAP       = RAM_DEPTH + 1;
  localparam int unsigned CW        = $clog2(RAM_DEPTH + 2);
  localparam int unsigned PF_SLOTS  = BF_READ_STAGES + 1;
  localparam int unsigned SW        = $clog2(PF_SLOTS + 1);

  logic push_ok, pop_ok, bypass, to_ram, issue, arrive, pf_wr;
  logic [AW-1:0]     wr_ptr, rd_ptr, wr_addr_q, rd_addr_q;
  logic [DATA_W-1:0] wr_data_q, mrg_data, pf_wdata;
  logic              wr_v_q, rd_v_q;
  logic [AW:0]       ram_pend;
  logic [SW-1:0]     inflight, pf_cnt, pf_cnt_nxt;
  logic [SW:0]       occ, room;
  logic [CW-1:0]     count, count_nxt;
  logic [N_BANKS-1:0][DATA_W-1:0] bank_q;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // Slot credit: slots filled plus reads in flight must stay within capacity,
  // counting the slot released by a pop in this cycle.
  assign occ  = {1'b0, pf_cnt} + {1'b0, inflight};
  assign room = (SW+1)'(PF_SLOTS) + (SW+1)'(pop_ok);

  assign issue  = (ram_pend != '0) && (occ < room);
  assign bypass = push_ok && (ram_pend == '0) && (inflight == '0) &&
                  ({1'b0, pf_cnt} < room);
  assign to_ram = push_ok && !bypass;

  assign pf_wr    = bypass || arrive;
  assign pf_wdata = bypass ? push_data : mrg_data;

  assign count_nxt  = count + CW'(push_ok) - CW'(pop_ok);
  assign pf_cnt_nxt = pf_cnt + SW'(pf_wr) - SW'(pop_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      wr_v_q     <= 1'b0;
      rd_v_q     <= 1'b0;
      ram_pend   <= '0;
      inflight   <= '0;
      count      <= '0;
      full       <= 1'b0;
      empty      <= 1'b1;
      prog_full  <= 1'b0;
      prog_empty <= 1'b1;
      overflow   <= 1'b0;
      underflow  <= 1'b0;
    end else begin
      wr_v_q <= to_ram;
      if (to_ram) begin
        wr_addr_q <= wr_ptr;
        wr_data_q <= push_data;
        wr_ptr    <= wr_ptr + AW'(1);
      end
      rd_v_q <= issue;
      if (issue) begin
        rd_addr_q <= rd_ptr;
        rd_ptr    <= rd_ptr + AW'(1);
      end
      ram_pend   <= ram_pend + (AW+1)'(to_ram) - (AW+1)'(issue);
      inflight   <= inflight + SW'(issue) - SW'(arrive);
      count      <= count_nxt;
      full       <= (count_nxt == CW'(CAP));
      empty      <= (pf_cnt_nxt == '0);
      prog_full  <= (count_nxt >= CW'(PROG_FULL_TH));
      prog_empty <= (count_nxt <= CW'(PROG_EMPTY_TH));
      overflow   <= push && full;
      underflow  <= pop && empty;
    end
  end

  assign level = count;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    bfifo_bank_ram #(
      .W     (DATA_W),
      .DEPTH (BANK_DEPTH)
    ) u_ram (
      .clk   (clk),
      .we    (wr_v_q && (wr_addr_q[AW-1 -: BSW] == BSW'(b))),
      .waddr (wr_addr_q[BAW-1:0]),
      .wdata (wr_data_q),
      .re    (rd_v_q && (rd_addr_q[AW-1 -: BSW] == BSW'(b))),
      .raddr (rd_addr_q[BAW-1:0]),
      .rdata (bank_q[b])
    );
  end

  bfifo_read_merge #(
    .W       (DATA_W),
    .N_BANKS (N_BANKS),
    .GROUP   (BF_GROUP_SIZE)
  ) u_merge (
    .clk      (clk),
    .rst      (rst),
    .in_v     (rd_v_q),
    .in_bank  (rd_addr_q[AW-1 -: BSW]),
    .bank_q   (bank_q),
    .out_v    (arrive),
    .out_data (mrg_data)
  );

  bfifo_prefetch #(
    .W     (DATA_W),
    .SLOTS (PF_SLOTS)
  ) u_pf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (pf_wr),
    .wr_data (pf_wdata),
    .rd_en   (pop_ok),
    .head    (pop_data),
    .cnt     (pf_cnt)
  );

endmodule

// File: rtl/bfifo_checks.sv
module bfifo_checks #(
  parameter int unsigned CAP   = 8193,
  parameter int unsigned PF_TH = 8001,
  parameter int unsigned PE_TH = 10,
  parameter int unsigned LVW   = 14,
  parameter int unsigned DW    = 72
) (
  input logic           clk,
  input logic           rst,
  input logic           push,
  input logic           pop,
  input logic           full,
  input logic           empty,
  input logic           prog_full,
  input logic           prog_empty,
  input logic           overflow,
  input logic           underflow,
  input logic [LVW-1:0] level,
  input logic [DW-1:0]  pop_data
);

  a_r6_overflow_pulse: assert property (@(posedge clk) disable iff (rst)
    push && full |=> overflow);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !(push && full) |=> !overflow);

  a_r6_level_held: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop |=> level == $past(level));

  a_r7_underflow_pulse: assert property (@(posedge clk) disable iff (rst)
    pop && empty |=> underflow);

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty) |=> !underflow);

  a_r8_level_up: assert property (@(posedge clk) disable iff (rst)
    push && !full && !(pop && !empty) |=> level == $past(level) + LVW'(1));

  a_r8_level_down: assert property (@(posedge clk) disable iff (rst)
    !(push && !full) && pop && !empty |=> level == $past(level) - LVW'(1));

  a_r11_level_same: assert property (@(posedge clk) disable iff (rst)
    push && !full && pop && !empty |=> level == $past(level));

  a_r5_full_at_cap: assert property (@(posedge clk) disable iff (rst)
    full == (level == LVW'(CAP)));

  a_r5_empty_when_zero: assert property (@(posedge clk) disable iff (rst)
    level == '0 |-> empty);

  a_r9_prog_full: assert property (@(posedge clk) disable iff (rst)
    prog_full == (level >= LVW'(PF_TH)));

  a_r10_prog_empty: assert property (@(posedge clk) disable iff (rst)
    prog_empty == (level <= LVW'(PE_TH)));

  a_r12_head_stable: assert property (@(posedge clk) disable iff (rst)
    !empty && !pop |=> $stable(pop_data));

endmodule

bind bfifo_top bfifo_checks #(
  .CAP   (BANK_DEPTH * N_BANKS + 1),
  .PF_TH (PROG_FULL_TH),
  .PE_TH (PROG_EMPTY_TH),
  .LVW   ($clog2(BANK_DEPTH * N_BANKS + 2)),
  .DW    (DATA_W)
) u_checks (
  .clk        (clk),
  .rst        (rst),
  .push       (push),
  .pop        (pop),
  .full       (full),
  .empty      (empty),
  .prog_full  (prog_full),
  .prog_empty (prog_empty),
  .overflow   (overflow),
  .underflow  (underflow),
  .level      (level),
  .pop_data   (pop_data)
);

// File: tb/test_bfifo_top.sv
module test_bfifo_top;

  localparam int unsigned CAP = 8193;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push = 1'b0;
  logic [71:0] push_data = '0;
  logic        pop = 1'b0;
  logic        full, empty, prog_full, prog_empty, overflow, underflow;
  logic [71:0] pop_data;
  logic [13:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bfifo_top i_bfifo_top (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data), .full(full),
    .pop(pop), .pop_data(pop_data), .empty(empty), .prog_full(prog_full),
    .prog_empty(prog_empty), .level(level), .overflow(overflow),
    .underflow(underflow)
  );

  typedef struct packed {
    logic        psh;
    logic        pp;
    logic [15:0] tag;
    logic [15:0] ptag;
    logic [13:0] lvl;
    logic        emp;
    logic        uf;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0011, 16'h0000, 14'd1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h0012, 16'h0000, 14'd2, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0011, 14'd1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 16'h0013, 16'h0012, 14'd1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0013, 14'd0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0000, 14'd0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 16'h0014, 16'h0000, 14'd1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h0015, 16'h0000, 14'd2, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h0016, 16'h0000, 14'd3, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h0017, 16'h0000, 14'd4, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h0018, 16'h0000, 14'd5, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h0019, 16'h0000, 14'd6, 1'b0, 1'b0},
    '{1'b1, 1'b0, 16'h001A, 16'h0000, 14'd7, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0014, 14'd6, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0015, 14'd5, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0016, 14'd4, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0017, 14'd3, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0018, 14'd2, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h0019, 14'd1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 16'h001A, 14'd0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 16'h001B, 16'h0000, 14'd1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 16'h0000, 16'h001B, 14'd0, 1'b1, 1'b0}
  };

  function automatic logic [71:0] mk(input logic [15:0] t);
    return {t, ~t, t ^ 16'h5a5a, ~t ^ 16'h0f0f, t[7:0]};
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; push = 1'b0; pop = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 empty", 72'(empty), 72'(1));
    check("R1 full", 72'(full), 72'(0));
    check("R1 level", 72'(level), 72'(0));
    check("R1 prog_empty", 72'(prog_empty), 72'(1));
    check("R1 prog_full", 72'(prog_full), 72'(0));
    check("R1 overflow", 72'(overflow), 72'(0));
    check("R1 underflow", 72'(underflow), 72'(0));
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();

    // Table walk: R2 order, R3 empty-to-valid, R4 RAM handover, R7, R8, R11
    for (int i = 0; i < NV; i++) begin
      push      = VECS[i].psh;
      pop       = VECS[i].pp;
      push_data = mk(VECS[i].tag);
      if (VECS[i].pp && !VECS[i].uf)
        check("R2 head word", pop_data, mk(VECS[i].ptag));
      @(negedge clk);
      check("R8 level", 72'(level), 72'(VECS[i].lvl));
      check("R3 R4 empty", 72'(empty), 72'(VECS[i].emp));
      check("R7 underflow", 72'(underflow), 72'(VECS[i].uf));
    end
    push = 1'b0; pop = 1'b0;

    // Fill to capacity through every bank: R5, R9, R10
    do_reset();
    for (int k = 0; k < CAP; k++) begin
      push = 1'b1;
      push_data = mk(16'(k));
      @(negedge clk);
      check("R8 fill level", 72'(level), 72'(k + 1));
      if (k + 1 == 10) check("R10 prog_empty at 10", 72'(prog_empty), 72'(1));
      if (k + 1 == 11) check("R10 prog_empty at 11", 72'(prog_empty), 72'(0));
      if (k + 1 == 8000) check("R9 prog_full at 8000", 72'(prog_full), 72'(0));
      if (k + 1 == 8001) check("R9 prog_full at 8001", 72'(prog_full), 72'(1));
      if (k + 1 == CAP - 1) check("R5 full below cap", 72'(full), 72'(0));
    end
    check("R5 full at cap", 72'(full), 72'(1));

    // R6: rejected push
    push = 1'b1;
    push_data = mk(16'hdead);
    @(negedge clk);
    check("R6 overflow pulse", 72'(overflow), 72'(1));
    check("R6 level held", 72'(level), 72'(CAP));
    push = 1'b0;
    @(negedge clk);
    check("R6 overflow one cycle", 72'(overflow), 72'(0));

    // R12: head holds while idle
    for (int j = 0; j < 3; j++) begin
      check("R12 head stable", pop_data, mk(16'h0000));
      @(negedge clk);
    end

    // Full-rate drain: R4, R5, R2
    for (int k = 0; k < CAP; k++) begin
      pop = 1'b1;
      if (empty !== 1'b0) check("R4 empty during drain", 72'(empty), 72'(0));
      if (pop_data !== mk(16'(k))) check("R5 drained word", pop_data, mk(16'(k)));
      checks++;
      @(negedge clk);
    end
    pop = 1'b0;
    check("R5 empty after drain", 72'(empty), 72'(1));
    check("R6 rejected word absent", 72'(level), 72'(0));
    check("R10 prog_empty after drain", 72'(prog_empty), 72'(1));
    check("R9 prog_full after drain", 72'(prog_full), 72'(0));

    // R1: reset in the middle of traffic
    for (int k = 0; k < 3; k++) begin
      push = 1'b1;
      push_data = mk(16'(k + 100));
      @(negedge clk);
    end
    push = 1'b0;
    do_reset();
    @(negedge clk);
    check("R1 empty after reset", 72'(empty), 72'(1));
    check("R1 level after reset", 72'(level), 72'(0));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule